// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block is the test-access slice that sits between a core's port logic and one bidirectional I/O pad with a weak pull-up. It holds two scan stages. The first stage carries the pad's output-enable, which is the pin's direction bit. The second stage carries the pad's output value. Each stage has a capture/shift flip-flop and an update register. The serial path runs from `scan_in` through the direction stage and then the data stage to `scan_out`.

In normal operation the core's direction and data bits drive the pad. The pad can also be handed to a clock-output function. When the external-test instruction is active, the update registers take over the pad and the pull-up is switched off. Under either the external-test or the sample/preload instruction, the clock-output function is kept off the pin. The value the core reads is always taken straight from the pad.

The block does not contain the TAP controller or the instruction decoder. That logic supplies the shift, capture-clock and update enables, and the decoded instruction flags.

Top module: `bscan_bidir_cell`

## Requirements
- R1: While `trst_n` is low, both scan flip-flops and both update registers are 0. As a result `scan_out` is 0, and with `ir_extest` high `pad_oe` and `pad_do` are both 0 (pin tri-stated).
- R2: On a rising `tck` with `dr_clk_en` and `dr_shift` both high, the direction stage loads `scan_in` and the data stage loads the previous direction-stage value. `scan_out` is the data-stage flip-flop, so a bit reaches `scan_out` after two shifts.
- R3: On a rising `tck` with `dr_clk_en` high and `dr_shift` low, the direction stage captures `port_dir` and the data stage captures `pad_in`, the actual pad level.
- R4: On a rising `tck` with `dr_update` high, both update registers copy their scan flip-flops. At all other times they hold, including while shifting.
- R5: With `ir_extest` high, `pad_oe` equals the direction update register and `pad_do` equals the data update register.
- R6: With `ir_extest` low and the clock-output path inactive, `pad_oe` follows `port_dir` and `pad_do` follows `port_out`. This includes operation under `ir_sample`.
- R7: With `ckout_en` high and both `ir_extest` and `ir_sample` low, `pad_oe` is 1 and `pad_do` follows `ckout_src`.
- R8: With `ir_extest` or `ir_sample` high, `ckout_en` has no effect on `pad_oe` or `pad_do`.
- R9: `pad_pue` is 1 only when all of the following hold: `pull_dis` is 0, `port_dir` is 0 (input), `port_out` is 1, and `ir_extest` is 0. Otherwise it is 0.
- R10: `core_in` equals `pad_in` in every mode.
- R11: With `dr_clk_en` low, both scan flip-flops hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| dr_clk_en | input | 1 | Enables the scan flip-flops on this edge |
| dr_shift | input | 1 | 1 = shift serially, 0 = capture in parallel |
| dr_update | input | 1 | Copies the scan flip-flops into the update registers |
| ir_extest | input | 1 | Decoded external-test instruction |
| ir_sample | input | 1 | Decoded sample/preload instruction |
| scan_in | input | 1 | Serial input from the previous cell |
| scan_out | output | 1 | Serial output to the next cell |
| port_dir | input | 1 | Functional direction bit, 1 = output |
| port_out | input | 1 | Functional output data bit |
| pull_dis | input | 1 | Global pull-up disable |
| ckout_en | input | 1 | Clock-output function enabled by configuration |
| ckout_src | input | 1 | Clock value to drive when clock output is active |
| pad_in | input | 1 | Level seen on the physical pad |
| pad_oe | output | 1 | Pad output enable |
| pad_do | output | 1 | Pad output data |
| pad_pue | output | 1 | Pad weak pull-up enable |
| core_in | output | 1 | Pin value returned to the core |

## Verification
The assertions assume that `ir_extest` and `ir_sample` are never high together, because the decoder selects only one instruction at a time. They also assume that `dr_update` is never raised on the same edge as `dr_clk_en`, as the TAP state sequence guarantees. The stimulus changes only one instruction flag at a time. It issues capture, shift and update as separate `tck` steps, and it drives all inputs on the falling edge so that every rising edge sees stable values.

// File: rtl/bscan_bidir_cell.sv
module bscan_bidir_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic dr_clk_en,
  input  logic dr_shift,
  input  logic dr_update,
  input  logic ir_extest,
  input  logic ir_sample,
  input  logic scan_in,
  output logic scan_out,
  input  logic port_dir,
  input  logic port_out,
  input  logic pull_dis,
  input  logic ckout_en,
  input  logic ckout_src,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_do,
  output logic pad_pue,
  output logic core_in
);

  logic oc_q, od_q;
  logic oc_upd, od_upd;
  logic ck_block, ck_drive;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      oc_q <= 1'b0;
      od_q <= 1'b0;
    end else if (dr_clk_en) begin
      oc_q <= dr_shift ? scan_in : port_dir;
      od_q <= dr_shift ? oc_q    : pad_in;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      oc_upd <= 1'b0;
      od_upd <= 1'b0;
    end else if (dr_update) begin
      oc_upd <= oc_q;
      od_upd <= od_q;
    end
  end

  assign scan_out = od_q;
  assign ck_block = ir_extest | ir_sample;
  assign ck_drive = ckout_en & ~ck_block;

  assign pad_oe  = ir_extest ? oc_upd : (ck_drive | port_dir);
  assign pad_do  = ir_extest ? od_upd : (ck_drive ? ckout_src : port_out);
  assign pad_pue = ~pull_dis & ~port_dir & port_out & ~ir_extest;
  assign core_in = pad_in;

  a_r2_shift_oc: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && dr_shift) |=> (oc_q == $past(scan_in)));
  a_r2_shift_out: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && dr_shift) |=> (scan_out == $past(oc_q)));
  a_r3_capture_pad: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && !dr_shift) |=> (scan_out == $past(pad_in)));
  a_r4_update_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !dr_update |=> ($stable(oc_upd) && $stable(od_upd)));
  a_r11_scan_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !dr_clk_en |=> ($stable(oc_q) && $stable(scan_out)));
  a_r8_no_ckout_sample: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_sample && !ir_extest) |-> (pad_oe == port_dir && pad_do == port_out));
  a_r9_pue_extest: assert property (@(posedge tck) disable iff (!trst_n)
    ir_extest |-> !pad_pue);
  a_r10_core_in: assert property (@(posedge tck) disable iff (!trst_n)
    core_in == pad_in);

endmodule

// File: tb/bscan_bidir_cell_tb.sv
module bscan_bidir_cell_tb;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic dr_clk_en = 0, dr_shift = 0, dr_update = 0;
  logic ir_extest = 0, ir_sample = 0, scan_in = 0;
  logic port_dir = 0, port_out = 0, pull_dis = 0;
  logic ckout_en = 0, ckout_src = 0, pad_in = 0;
  logic scan_out, pad_oe, pad_do, pad_pue, core_in;
  int checks = 0, errors = 0;

  always #10 tck = ~tck;

  bscan_bidir_cell u_dut (
    .tck(tck), .trst_n(trst_n), .dr_clk_en(dr_clk_en), .dr_shift(dr_shift),
    .dr_update(dr_update), .ir_extest(ir_extest), .ir_sample(ir_sample),
    .scan_in(scan_in), .scan_out(scan_out), .port_dir(port_dir),
    .port_out(port_out), .pull_dis(pull_dis), .ckout_en(ckout_en),
    .ckout_src(ckout_src), .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
    .pad_pue(pad_pue), .core_in(core_in)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    dr_clk_en = 0; dr_shift = 0; dr_update = 0;
    @(negedge tck);
  endtask

  task automatic shift_bit(logic b);
    dr_clk_en = 1; dr_shift = 1; dr_update = 0; scan_in = b;
    @(negedge tck);
    dr_clk_en = 0; dr_shift = 0;
  endtask

  task automatic capture();
    dr_clk_en = 1; dr_shift = 0; dr_update = 0;
    @(negedge tck);
    dr_clk_en = 0;
  endtask

  task automatic update();
    dr_clk_en = 0; dr_update = 1;
    @(negedge tck);
    dr_update = 0;
  endtask

  task automatic t_reset();
    ir_extest = 1; #1;
    check("R1 scan_out", scan_out, 1'b0);
    check("R1 pad_oe", pad_oe, 1'b0);
    check("R1 pad_do", pad_do, 1'b0);
    ir_extest = 0;
  endtask

  task automatic t_shift();
    shift_bit(1);
    check("R2 first shift", scan_out, 1'b0);
    shift_bit(0);
    check("R2 second shift", scan_out, 1'b1);
    shift_bit(1);
    check("R2 third shift", scan_out, 1'b0);
    idle(); idle();
    check("R11 hold", scan_out, 1'b0);
    shift_bit(0);
    check("R11 held oc", scan_out, 1'b1);
  endtask

  task automatic t_capture();
    port_dir = 1; pad_in = 0;
    capture();
    check("R3 capture pad 0", scan_out, 1'b0);
    shift_bit(0);
    check("R3 capture dir 1", scan_out, 1'b1);
    port_dir = 0; pad_in = 1;
    capture();
    check("R3 capture pad 1", scan_out, 1'b1);
    shift_bit(0);
    check("R3 capture dir 0", scan_out, 1'b0);
  endtask

  task automatic t_extest();
    shift_bit(0);
    shift_bit(1);
    update();
    port_dir = 0; port_out = 1; ckout_en = 1;
    ir_extest = 1; #1;
    check("R5 oe", pad_oe, 1'b1);
    check("R5 do", pad_do, 1'b0);
    check("R8 extest no ckout", pad_oe & ckout_src, 1'b0);
    check("R9 pue off extest", pad_pue, 1'b0);
    @(negedge tck);
    shift_bit(1); shift_bit(0);
    check("R4 oe held", pad_oe, 1'b1);
    check("R4 do held", pad_do, 1'b0);
    update(); #1;
    check("R4 oe updated", pad_oe, 1'b0);
    check("R4 do updated", pad_do, 1'b1);
    ir_extest = 0; ckout_en = 0;
    @(negedge tck);
  endtask

  task automatic t_functional();
    port_dir = 1; port_out = 0; #1;
    check("R6 oe", pad_oe, 1'b1);
    check("R6 do", pad_do, 1'b0);
    ir_sample = 1; port_out = 1; #1;
    check("R6 sample do", pad_do, 1'b1);
    ckout_en = 1; ckout_src = 0; port_dir = 0; #1;
    check("R8 sample oe", pad_oe, 1'b0);
    check("R8 sample do", pad_do, 1'b1);
    ir_sample = 0; #1;
    check("R7 oe", pad_oe, 1'b1);
    check("R7 do low", pad_do, 1'b0);
    ckout_src = 1; #1;
    check("R7 do high", pad_do, 1'b1);
    ckout_en = 0; #1;
    @(negedge tck);
  endtask

  task automatic t_pullup();
    pull_dis = 0; port_dir = 0; port_out = 1; #1;
    check("R9 pue on", pad_pue, 1'b1);
    pull_dis = 1; #1;
    check("R9 pue disabled", pad_pue, 1'b0);
    pull_dis = 0; port_dir = 1; #1;
    check("R9 pue output", pad_pue, 1'b0);
    port_dir = 0; port_out = 0; #1;
    check("R9 pue data 0", pad_pue, 1'b0);
    pad_in = 0; #1;
    check("R10 core 0", core_in, 1'b0);
    ir_extest = 1; pad_in = 1; #1;
    check("R10 core 1 extest", core_in, 1'b1);
    ir_extest = 0;
    @(negedge tck);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge tck); @(negedge tck);
    t_reset();
    trst_n = 1;
    @(negedge tck);
    t_shift();
    t_capture();
    t_extest();
    t_functional();
    t_pullup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule